// File: doc/BRIEF.md
# Instruction Length and Cycle Lookup Fetch Controller

This block sits beside the program-memory port of an 8051-compatible core. All code comes from external program memory. The block takes each opcode byte as it arrives and looks up two things: how many bytes the instruction occupies and how many machine cycles it runs. It then asks for exactly the number of operand bytes still missing. It keeps the first operand byte as parameter one and the second as parameter two. It counts phase ticks until the instruction's last machine cycle ends, and at that point it pulses done.

Both lookups use one shared 7-bit address, not a full 256-entry opcode table. The address joins a folded 3-bit code taken from the opcode's low nibble with the opcode's high nibble. The folding works because every register-direct opcode (low nibble 8..F) has the same length and timing for its group, and so does every register-indirect pair (low nibble 6..7).

When the opcode is an absolute call or a long call, the block builds the subroutine entry address from the captured bytes. It raises a call-valid flag for the program-counter logic while that instruction executes.

Top module: `insn_fetch_ctl`

## Requirements
- R1: A synchronous reset puts the block in the state that waits for an opcode: fetch_en_o=1, done_o=0, call_vld_o=0, both parameters 0x00, len_o=0 and cyc_o=0.
- R2: Lookup address = {fold(op[3:0]), op[7:4]}, where fold maps 8..F to 7, maps 6..7 to 6 and passes 0..5 through unchanged. As a result, 0x08 and 0x0F report 1 byte/1 cycle, 0xD8 and 0xDF report 2/2, and 0xD6 and 0xD7 report 1/1.
- R3: After an opcode is accepted, len_o gives its standard 8051 byte count. Examples: 0x00→1, 0x74→2, 0xE5→2, 0xA6→2, 0x01→2, 0x02→3, 0x12→3, 0x75→3, 0x85→3, 0x90→3, 0xB4→3, 0x84→1.
- R4: After an opcode is accepted, cyc_o gives its standard machine-cycle count in the range 1..4. Examples: 0x84 and 0xA4→4; 0x02, 0x12, 0x75, 0xE0, 0xA6 and 0x01→2; 0x00, 0x74 and 0xE5→1.
- R5: fetch_en_o is high while the block waits for an opcode or while operand bytes are still missing. It goes low once the last byte of the instruction has been captured and stays low until done_o.
- R6: The first byte after the opcode is stored as parameter one and the second as parameter two. Accepting an opcode clears both, so a parameter the instruction does not use reads 0x00.
- R7: Machine-cycle counting starts once all bytes are captured. Phase ticks that arrive earlier are ignored. done_o is a one-clock pulse that coincides with tick number PHASES×cycles, and the block then waits for the next opcode.
- R8: Bytes strobed while the instruction executes (fetch_en_o low) leave both parameters unchanged.
- R9: For an absolute call (op[4:0]=10001b), call_addr_o = {(PC+2)[15:11], op[7:5], param1}. Here PC is the opcode address on pc_i when the opcode is accepted, and PC+2 wraps at 16 bits.
- R10: For a long call (0x12), call_addr_o = {param1, param2}. call_vld_o is high only while a call executes, so it stays low for jumps such as 0x01 and 0x02.
- R11: A reset in the middle of an instruction abandons it. The block returns to the R1 state, and the next opcode is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_i | input | 8 | Byte read from program memory |
| byte_vld_i | input | 1 | byte_i is valid this clock |
| pc_i | input | PC_W | Address of the byte on byte_i |
| tick_i | input | 1 | Phase advance strobe |
| fetch_en_o | output | 1 | Block requests another program byte |
| len_o | output | 2 | Byte length of current instruction |
| cyc_o | output | 3 | Machine cycles of current instruction |
| done_o | output | 1 | Last phase of last cycle |
| pmem1_o | output | 8 | First operand byte |
| pmem2_o | output | 8 | Second operand byte |
| call_vld_o | output | 1 | Call target is valid |
| call_addr_o | output | PC_W | Subroutine entry address |

## Verification
The bench builds the block with PC_W=16 and PHASES=4. With a 16-bit counter, the wrap of PC+2 at 0xFFFE and a 2 KB page crossing at 0x07FF both show up in absolute-call targets. With four phases, the longest instructions need sixteen ticks before done. The stimulus table covers every length, every cycle count and both call forms. It also includes opcode pairs that differ only in the folded low nibble, so a fault in the folding shows up as a wrong length or cycle count.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    localparam int LEN_W = 2;
    localparam int CYC_W = 3;
    localparam int IDX_W = 7;
    localparam int TBL_N = 1 << IDX_W;

    typedef enum logic [1:0] {
        S_WAIT = 2'd0,
        S_OPND = 2'd1,
        S_RUN  = 2'd2
    } fsm_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [CYC_W-1:0] cyc;
    } ins_info_t;

    function automatic ins_info_t mk(input int l, input int c);
        ins_info_t r;
        r.len = LEN_W'(l);
        r.cyc = CYC_W'(c);
        return r;
    endfunction

    // Byte count and machine-cycle count for one folded lookup address.
    function automatic ins_info_t info_of(input logic [IDX_W-1:0] idx);
        logic [2:0] row;
        logic [3:0] hi;
        ins_info_t  r;
        row = idx[6:4];
        hi  = idx[3:0];
        unique case (row)
            3'd0: begin
                unique case (hi)
                    4'h0:                      r = mk(1, 1);
                    4'h1, 4'h2, 4'h3, 4'h9:    r = mk(3, 2);
                    4'hE, 4'hF:                r = mk(1, 2);
                    default:                   r = mk(2, 2);
                endcase
            end
            3'd1: r = mk(2, 2);
            3'd2: begin
                unique case (hi)
                    4'h0, 4'h1:                r = mk(3, 2);
                    4'h2, 4'h3, 4'hE, 4'hF:    r = mk(1, 2);
                    4'h7, 4'h8, 4'h9:          r = mk(2, 2);
                    default:                   r = mk(2, 1);
                endcase
            end
            3'd3: begin
                unique case (hi)
                    4'h4, 4'h5, 4'h6:          r = mk(3, 2);
                    4'h7, 4'h8, 4'h9, 4'hA,
                    4'hE, 4'hF:                r = mk(1, 2);
                    default:                   r = mk(1, 1);
                endcase
            end
            3'd4: begin
                unique case (hi)
                    4'h8, 4'hA:                r = mk(1, 4);
                    4'hB:                      r = mk(3, 2);
                    4'h2, 4'h3, 4'h4, 4'h5,
                    4'h6, 4'h7, 4'h9:          r = mk(2, 1);
                    default:                   r = mk(1, 1);
                endcase
            end
            3'd5: begin
                unique case (hi)
                    4'h7, 4'h8, 4'hB, 4'hD:    r = mk(3, 2);
                    4'hA:                      r = mk(1, 1);
                    default:                   r = mk(2, 1);
                endcase
            end
            default: begin
                // rows 6 (indirect) and 7 (register) differ only at hi=D
                unique case (hi)
                    4'h7:                      r = mk(2, 1);
                    4'h8, 4'hA:                r = mk(2, 2);
                    4'hB:                      r = mk(3, 2);
                    4'hD:                      r = (row == 3'd7) ? mk(2, 2) : mk(1, 1);
                    default:                   r = mk(1, 1);
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ifc_fold.sv
module ifc_fold
    import ifc_pkg::*;
(
    input  logic [7:0]       op_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [2:0] code;

    always_comb begin
        if (op_i[3])
            code = 3'd7;
        else if (op_i[2:1] == 2'b11)
            code = 3'd6;
        else
            code = op_i[2:0];
        idx_o = {code, op_i[7:4]};
    end
endmodule

// File: rtl/ifc_table.sv
module ifc_table
    import ifc_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output ins_info_t        info_o
);
    ins_info_t rom [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_rom
        assign rom[g] = info_of(IDX_W'(g));
    end

    assign info_o = rom[idx_i];
endmodule

// File: rtl/ifc_call.sv
module ifc_call #(
    parameter int PC_W = 16
) (
    input  logic [7:0]      op_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [7:0]      p1_i,
    input  logic [7:0]      p2_i,
    output logic            is_call_o,
    output logic [PC_W-1:0] tgt_o
);
    localparam int PAGE_W = 11;
    localparam logic [7:0] LONG_CALL = 8'h12;
    localparam logic [4:0] ABS_CALL  = 5'b10001;

    logic [PC_W-1:0] pc_next;
    logic            is_abs;
    logic            is_long;

    always_comb begin
        pc_next   = pc_i + PC_W'(2);
        is_abs    = (op_i[4:0] == ABS_CALL);
        is_long   = (op_i == LONG_CALL);
        is_call_o = is_abs | is_long;
        if (is_abs)
            tgt_o = {pc_next[PC_W-1:PAGE_W], op_i[7:5], p1_i};
        else
            tgt_o = PC_W'({p1_i, p2_i});
    end
endmodule

// File: rtl/insn_fetch_ctl.sv
module insn_fetch_ctl
    import ifc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PHASES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      byte_i,
    input  logic            byte_vld_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            tick_i,
    output logic            fetch_en_o,
    output logic [1:0]      len_o,
    output logic [2:0]      cyc_o,
    output logic            done_o,
    output logic [7:0]      pmem1_o,
    output logic [7:0]      pmem2_o,
    output logic            call_vld_o,
    output logic [PC_W-1:0] call_addr_o
);
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    typedef struct packed {
        fsm_e             st;
        logic [7:0]       op;
        logic [PC_W-1:0]  pc;
        logic [LEN_W-1:0] len;
        logic [CYC_W-1:0] cyc;
        logic [LEN_W-1:0] got;
        logic [7:0]       p1;
        logic [7:0]       p2;
        logic [PH_W-1:0]  ph;
        logic [CYC_W-1:0] cc;
    } regs_t;

    regs_t            q, d;
    logic             done_c;
    logic [IDX_W-1:0] idx;
    ins_info_t        lk;
    logic             is_call;
    logic [PC_W-1:0]  tgt;

    ifc_fold u_fold (
        .op_i  (byte_i),
        .idx_o (idx)
    );

    ifc_table u_tbl (
        .idx_i  (idx),
        .info_o (lk)
    );

    ifc_call #(.PC_W(PC_W)) u_call (
        .op_i      (q.op),
        .pc_i      (q.pc),
        .p1_i      (q.p1),
        .p2_i      (q.p2),
        .is_call_o (is_call),
        .tgt_o     (tgt)
    );

    always_comb begin
        d      = q;
        done_c = 1'b0;
        unique case (q.st)
            S_WAIT: begin
                if (byte_vld_i) begin
                    d.op  = byte_i;
                    d.pc  = pc_i;
                    d.len = lk.len;
                    d.cyc = lk.cyc;
                    d.p1  = '0;
                    d.p2  = '0;
                    d.got = '0;
                    d.ph  = '0;
                    d.cc  = '0;
                    d.st  = (lk.len == LEN_W'(1)) ? S_RUN : S_OPND;
                end
            end
            S_OPND: begin
                if (byte_vld_i) begin
                    if (q.got == '0)
                        d.p1 = byte_i;
                    else
                        d.p2 = byte_i;
                    d.got = q.got + LEN_W'(1);
                    if ((q.got + LEN_W'(2)) == q.len)
                        d.st = S_RUN;
                end
            end
            S_RUN: begin
                if (tick_i) begin
                    if (q.ph == PH_LAST) begin
                        d.ph = '0;
                        if (q.cc == (q.cyc - CYC_W'(1))) begin
                            done_c = 1'b1;
                            d.st   = S_WAIT;
                        end else begin
                            d.cc = q.cc + CYC_W'(1);
                        end
                    end else begin
                        d.ph = q.ph + PH_W'(1);
                    end
                end
            end
            default: d.st = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

    assign fetch_en_o  = (q.st != S_RUN);
    assign len_o       = q.len;
    assign cyc_o       = q.cyc;
    assign done_o      = done_c;
    assign pmem1_o     = q.p1;
    assign pmem2_o     = q.p2;
    assign call_vld_o  = (q.st == S_RUN) && is_call;
    assign call_addr_o = tgt;
endmodule

// File: rtl/insn_fetch_ctl_chk.sv
module insn_fetch_ctl_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            byte_vld_i,
    input logic            fetch_en_o,
    input logic [1:0]      len_o,
    input logic [2:0]      cyc_o,
    input logic            done_o,
    input logic [7:0]      pmem1_o,
    input logic [7:0]      pmem2_o,
    input logic            call_vld_o,
    input logic [PC_W-1:0] call_addr_o
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (fetch_en_o && !done_o && !call_vld_o &&
                 pmem1_o == 8'h00 && pmem2_o == 8'h00 && len_o == 2'd0));

    a_r3_len_cyc_range: assert property (@(posedge clk) disable iff (rst)
        !fetch_en_o |-> (len_o != 2'd0 && cyc_o != 3'd0 && cyc_o <= 3'd4));

    a_r7_done_in_exec: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !fetch_en_o);

    a_r7_done_then_wait: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (fetch_en_o && !done_o));

    a_r8_bytes_ignored: assert property (@(posedge clk) disable iff (rst)
        (!fetch_en_o && byte_vld_i) |=> ($stable(pmem1_o) && $stable(pmem2_o)));

    a_r10_call_in_exec: assert property (@(posedge clk) disable iff (rst)
        call_vld_o |-> !fetch_en_o);

    a_r10_call_held: assert property (@(posedge clk) disable iff (rst)
        (call_vld_o && !done_o) |=> (call_vld_o && $stable(call_addr_o)));
endmodule

bind insn_fetch_ctl insn_fetch_ctl_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .byte_vld_i  (byte_vld_i),
    .fetch_en_o  (fetch_en_o),
    .len_o       (len_o),
    .cyc_o       (cyc_o),
    .done_o      (done_o),
    .pmem1_o     (pmem1_o),
    .pmem2_o     (pmem2_o),
    .call_vld_o  (call_vld_o),
    .call_addr_o (call_addr_o)
);

// File: tb/insn_fetch_ctl_tb.sv
module insn_fetch_ctl_tb;
    localparam int CLK_P  = 10;
    localparam int PC_W   = 16;
    localparam int PHASES = 4;
    localparam int NV     = 24;

    typedef struct packed {
        logic [15:0] pc;
        logic [7:0]  op;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [1:0]  len;
        logic [2:0]  cyc;
        logic        call;
        logic [15:0] addr;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{16'h0000, 8'h00, 8'h00, 8'h00, 2'd1, 3'd1, 1'b0, 16'h0000},
        '{16'h0010, 8'h74, 8'h5A, 8'h00, 2'd2, 3'd1, 1'b0, 16'h0000},
        '{16'h0020, 8'h02, 8'h12, 8'h34, 2'd3, 3'd2, 1'b0, 16'h0000},
        '{16'h0030, 8'h12, 8'hAB, 8'hCD, 2'd3, 3'd2, 1'b1, 16'hABCD},
        '{16'h0040, 8'h00, 8'h00, 8'h00, 2'd1, 3'd1, 1'b0, 16'h0000},
        '{16'h47FE, 8'h31, 8'h77, 8'h00, 2'd2, 3'd2, 1'b1, 16'h4977},
        '{16'hFFFE, 8'hF1, 8'h10, 8'h00, 2'd2, 3'd2, 1'b1, 16'h0710},
        '{16'h07FF, 8'h51, 8'h33, 8'h00, 2'd2, 3'd2, 1'b1, 16'h0A33},
        '{16'h0100, 8'h01, 8'h44, 8'h00, 2'd2, 3'd2, 1'b0, 16'h0000},
        '{16'h0200, 8'h84, 8'h00, 8'h00, 2'd1, 3'd4, 1'b0, 16'h0000},
        '{16'h0201, 8'hA4, 8'h00, 8'h00, 2'd1, 3'd4, 1'b0, 16'h0000},
        '{16'h0202, 8'h08, 8'h00, 8'h00, 2'd1, 3'd1, 1'b0, 16'h0000},
        '{16'h0203, 8'h0F, 8'h00, 8'h00, 2'd1, 3'd1, 1'b0, 16'h0000},
        '{16'h0204, 8'hD8, 8'h9C, 8'h00, 2'd2, 3'd2, 1'b0, 16'h0000},
        '{16'h0206, 8'hDF, 8'h9D, 8'h00, 2'd2, 3'd2, 1'b0, 16'h0000},
        '{16'h0208, 8'hD6, 8'h00, 8'h00, 2'd1, 3'd1, 1'b0, 16'h0000},
        '{16'h0209, 8'hD7, 8'h00, 8'h00, 2'd1, 3'd1, 1'b0, 16'h0000},
        '{16'h020A, 8'h75, 8'h30, 8'h55, 2'd3, 3'd2, 1'b0, 16'h0000},
        '{16'h020D, 8'hB4, 8'h20, 8'hFE, 2'd3, 3'd2, 1'b0, 16'h0000},
        '{16'h0210, 8'h85, 8'h11, 8'h22, 2'd3, 3'd2, 1'b0, 16'h0000},
        '{16'h0213, 8'hE5, 8'hF0, 8'h00, 2'd2, 3'd1, 1'b0, 16'h0000},
        '{16'h0215, 8'h90, 8'h12, 8'h00, 2'd3, 3'd2, 1'b0, 16'h0000},
        '{16'h0218, 8'hE0, 8'h00, 8'h00, 2'd1, 3'd2, 1'b0, 16'h0000},
        '{16'h0219, 8'hA6, 8'h40, 8'h00, 2'd2, 3'd2, 1'b0, 16'h0000}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      byte_i = 8'h00;
    logic            byte_vld_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic            tick_i = 1'b0;
    logic            fetch_en_o;
    logic [1:0]      len_o;
    logic [2:0]      cyc_o;
    logic            done_o;
    logic [7:0]      pmem1_o;
    logic [7:0]      pmem2_o;
    logic            call_vld_o;
    logic [PC_W-1:0] call_addr_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P / 2) clk = ~clk;

    insn_fetch_ctl #(.PC_W(PC_W), .PHASES(PHASES)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .byte_i      (byte_i),
        .byte_vld_i  (byte_vld_i),
        .pc_i        (pc_i),
        .tick_i      (tick_i),
        .fetch_en_o  (fetch_en_o),
        .len_o       (len_o),
        .cyc_o       (cyc_o),
        .done_o      (done_o),
        .pmem1_o     (pmem1_o),
        .pmem2_o     (pmem2_o),
        .call_vld_o  (call_vld_o),
        .call_addr_o (call_addr_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [15:0] pc);
        @(negedge clk);
        byte_i     = b;
        pc_i       = pc;
        byte_vld_i = 1'b1;
        @(negedge clk);
        byte_vld_i = 1'b0;
        #1;
    endtask

    task automatic one_tick();
        @(negedge clk);
        tick_i = 1'b1;
        #1;
        check("R7", "done during operand fetch", 32'(done_o), 32'd0);
        @(negedge clk);
        tick_i = 1'b0;
        #1;
    endtask

    // returns the tick number on which done appeared, 0 if never
    task automatic run_ticks(output int hit);
        hit = 0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            tick_i = 1'b1;
            #1;
            if (done_o) begin
                hit = n;
                break;
            end
        end
        @(negedge clk);
        tick_i = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int hit;
        logic [7:0] e1, e2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "fetch_en", 32'(fetch_en_o), 32'd1);
        check("R1", "done", 32'(done_o), 32'd0);
        check("R1", "call_vld", 32'(call_vld_o), 32'd0);
        check("R1", "pmem1", 32'(pmem1_o), 32'd0);
        check("R1", "pmem2", 32'(pmem2_o), 32'd0);
        check("R1", "len", 32'(len_o), 32'd0);
        check("R1", "cyc", 32'(cyc_o), 32'd0);

        // table walk: R2 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < NV; i++) begin
            send_byte(VEC[i].op, VEC[i].pc);
            check("R3", "len", 32'(len_o), 32'(VEC[i].len));
            check("R4", "cyc", 32'(cyc_o), 32'(VEC[i].cyc));
            check("R5", "fetch_en after opcode", 32'(fetch_en_o),
                  32'(VEC[i].len > 2'd1));
            if (VEC[i].len > 2'd1) send_byte(VEC[i].b1, VEC[i].pc + 16'd1);
            if (VEC[i].len > 2'd2) send_byte(VEC[i].b2, VEC[i].pc + 16'd2);
            e1 = (VEC[i].len > 2'd1) ? VEC[i].b1 : 8'h00;
            e2 = (VEC[i].len > 2'd2) ? VEC[i].b2 : 8'h00;
            check("R5", "fetch_en in exec", 32'(fetch_en_o), 32'd0);
            check("R6", "pmem1", 32'(pmem1_o), 32'(e1));
            check("R6", "pmem2", 32'(pmem2_o), 32'(e2));
            check("R10", "call_vld", 32'(call_vld_o), 32'(VEC[i].call));
            if (VEC[i].call) begin
                if (VEC[i].op[4:0] == 5'b10001)
                    check("R9", "abs call target", 32'(call_addr_o), 32'(VEC[i].addr));
                else
                    check("R10", "long call target", 32'(call_addr_o), 32'(VEC[i].addr));
            end
            run_ticks(hit);
            check("R7", "done tick", 32'(hit), 32'(PHASES * int'(VEC[i].cyc)));
            check("R5", "fetch_en after done", 32'(fetch_en_o), 32'd1);
            check("R7", "done pulse width", 32'(done_o), 32'd0);
        end

        // R7: ticks during operand fetch are not counted
        send_byte(8'h75, 16'h0300);
        one_tick();
        one_tick();
        send_byte(8'h66, 16'h0301);
        one_tick();
        one_tick();
        one_tick();
        send_byte(8'h77, 16'h0302);
        run_ticks(hit);
        check("R7", "early ticks ignored", 32'(hit), 32'(PHASES * 2));

        // R8: bytes during execution are ignored
        send_byte(8'h74, 16'h0310);
        send_byte(8'h5A, 16'h0311);
        send_byte(8'hEE, 16'h0312);
        send_byte(8'hDD, 16'h0313);
        check("R8", "pmem1 kept", 32'(pmem1_o), 32'h5A);
        check("R8", "pmem2 kept", 32'(pmem2_o), 32'h00);
        check("R8", "len kept", 32'(len_o), 32'd2);
        run_ticks(hit);
        check("R8", "done tick unaffected", 32'(hit), 32'(PHASES));

        // R11: reset mid-instruction
        send_byte(8'h12, 16'h0400);
        send_byte(8'h99, 16'h0401);
        do_reset();
        check("R11", "fetch_en", 32'(fetch_en_o), 32'd1);
        check("R11", "pmem1", 32'(pmem1_o), 32'd0);
        check("R11", "len", 32'(len_o), 32'd0);
        check("R11", "call_vld", 32'(call_vld_o), 32'd0);
        send_byte(8'h00, 16'h0500);
        check("R11", "len after restart", 32'(len_o), 32'd1);
        check("R11", "fetch_en after restart", 32'(fetch_en_o), 32'd0);
        run_ticks(hit);
        check("R11", "done after restart", 32'(hit), 32'(PHASES));

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule